// File: doc/BRIEF.md
# Tone Transceiver Host Register Interface

This block is the processor-facing side of a dual-tone transceiver. A host uses a 4-bit bidirectional data bus, an active-low chip select, separate active-low read and write strobes and one register-select line. Through these it writes a transmit digit, reads back the last received digit, programs two control nibbles and polls a status nibble. The tone generator and the tone detector sit outside the block. They talk to it through one-cycle strobes and a tone-present level.

The two control nibbles share one address. A control write normally lands in the primary nibble. When that write has bit 3 set, the next control write lands in the secondary nibble, and later writes go back to the primary one. Status flags record a received digit, an empty transmit register in burst mode and a pending interrupt. All three clear when the host reads the status nibble. A fourth status bit shows that no tone is present. An active-low interrupt line reports received digits and finished bursts while interrupts are enabled.

Host strobes are sampled on the system clock. A write takes effect one clock after it is first seen. Status flags clear once per read, when the read strobe is released.

Top module: `tone_host_regs`

## Requirements
- R1: After reset, `tx_data`, `ctrl_a` and `ctrl_b` are 0, `irq_n` is 1, no tx_load pulse is issued, and a status read returns 4'b1000 while `tone_det` is low.
- R2: A write with `reg_sel`=0 loads the data nibble into `tx_data`, and `tx_load` pulses high for exactly one clock in the same cycle.
- R3: A read with `reg_sel`=0 returns the code that was latched from `rx_code` on the most recent `rx_stb`. Reading the status nibble does not change this value.
- R4: The block drives `data` only while `cs_n`=0 and `rd_n`=0. With either one high, a value driven onto the bus by another agent reads back unchanged.
- R5: Control writes (`reg_sel`=1) load `ctrl_a`. If the value written has bit 3 set, the following control write loads `ctrl_b` instead, leaves `ctrl_a` unchanged, and returns steering to `ctrl_a`.
- R6: A read with `reg_sel`=1 returns status bit 0 = interrupt pending, bit 1 = transmit empty, bit 2 = receive full, bit 3 = no tone present.
- R7: `rx_stb` sets receive-full. `tx_stb` sets transmit-empty only when `ctrl_b` bit 0 is 0 (burst mode enabled). When `ctrl_b` bit 0 is 1, `tx_stb` leaves status unchanged.
- R8: Status bits 0 to 2 that were visible during a status read are cleared, once, two clocks after the read strobe is released. A flag set by a strobe on that clearing edge survives.
- R9: Status bit 3 equals the inverse of `tone_det`, one clock late. A status read does not clear it.
- R10: While `ctrl_a` bit 2 (interrupt enable) is 1, a received digit or a burst-mode transmit strobe sets the interrupt flag and drives `irq_n` low.
- R11: While `ctrl_a` bit 2 is 0, `irq_n` is held high and strobes do not set the interrupt flag. Clearing the enable masks a pending interrupt at once.
- R12: A status read that shows the interrupt flag returns `irq_n` high once the clearing edge has passed.
- R13: Strobes given while `cs_n` is high change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| reg_sel | input | 1 | 0: data registers, 1: control/status |
| data | inout | 4 | Host data bus |
| rx_stb | input | 1 | One-cycle strobe from the detector: new digit on rx_code |
| rx_code | input | 4 | Digit code from the detector |
| tx_stb | input | 1 | One-cycle strobe from the generator: burst finished |
| tone_det | input | 1 | High while the detector sees a valid tone |
| tx_data | output | 4 | Transmit digit for the generator |
| tx_load | output | 1 | One-cycle pulse when tx_data is written |
| ctrl_a | output | 4 | Primary control nibble |
| ctrl_b | output | 4 | Secondary control nibble |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions assume that `rx_stb` and `tx_stb` are single-cycle pulses synchronous to `clk`. They also assume that the host holds `reg_sel` and the write data stable for the whole time a strobe is low, and never asserts read and write together. The bench changes every input on the falling clock edge and holds each strobe low for two full clocks. It spaces bus cycles at least two clocks apart, so each access produces exactly one sampled edge pulse. Detector and generator strobes last one clock. The only strobe placed next to a bus access is the one aimed at the clearing edge, and it is placed there on purpose.

// File: rtl/tone_host_pkg.sv
package tone_host_pkg;
  localparam int NIB = 4;

  // status nibble bit positions (host software decodes these)
  localparam int ST_IRQ    = 0;
  localparam int ST_TXE    = 1;
  localparam int ST_RXF    = 2;
  localparam int ST_NOTONE = 3;
  localparam int ST_CLR_N  = 3;  // number of clear-on-read flags

  // primary control nibble
  localparam int CA_TONE_EN = 0;
  localparam int CA_CPMODE  = 1;
  localparam int CA_IE      = 2;
  localparam int CA_STEER   = 3;

  // secondary control nibble
  localparam int CB_BURST_N = 0;
  localparam int CB_TEST    = 1;
  localparam int CB_SINGLE  = 2;
  localparam int CB_COLUMN  = 3;

  typedef enum logic { TGT_A = 1'b0, TGT_B = 1'b1 } ctrl_tgt_e;
endpackage

// File: rtl/host_strobe_sampler.sv
module host_strobe_sampler
  import tone_host_pkg::*;
#(
  parameter int W = NIB
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic         sel,
  input  logic [W-1:0] din,
  output logic         wr_go,
  output logic         wr_sel,
  output logic [W-1:0] wr_dat,
  output logic         rd_seen,
  output logic         rd_sel,
  output logic         rd_done
);
  logic         wr_act, rd_act;
  logic         wr_q1, wr_q2, rd_q1, rd_q2;
  logic         wr_sel_q, wr_sel_d, rd_sel_q, rd_sel_d;
  logic [W-1:0] wr_dat_q, wr_dat_d;

  always_comb begin
    wr_act   = ~cs_n & ~wr_n;
    rd_act   = ~cs_n & ~rd_n;
    wr_sel_d = wr_sel_q;
    wr_dat_d = wr_dat_q;
    rd_sel_d = rd_sel_q;
    if (wr_act) begin
      wr_sel_d = sel;
      wr_dat_d = din;
    end
    if (rd_act) begin
      rd_sel_d = sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q1    <= 1'b0;
      wr_q2    <= 1'b0;
      rd_q1    <= 1'b0;
      rd_q2    <= 1'b0;
      wr_sel_q <= 1'b0;
      wr_dat_q <= '0;
      rd_sel_q <= 1'b0;
    end else begin
      wr_q1    <= wr_act;
      wr_q2    <= wr_q1;
      rd_q1    <= rd_act;
      rd_q2    <= rd_q1;
      wr_sel_q <= wr_sel_d;
      wr_dat_q <= wr_dat_d;
      rd_sel_q <= rd_sel_d;
    end
  end

  assign wr_go   = wr_q1 & ~wr_q2;
  assign wr_sel  = wr_sel_q;
  assign wr_dat  = wr_dat_q;
  assign rd_seen = rd_q1;
  assign rd_sel  = rd_sel_q;
  assign rd_done = rd_q2 & ~rd_q1;

  // one write event per strobe: a pulse is never followed by another pulse
  p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> !wr_go);
  p_single_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);
endmodule

// File: rtl/ctrl_bank.sv
module ctrl_bank
  import tone_host_pkg::*;
#(
  parameter int W = NIB
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_go,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_dat,
  output logic [W-1:0] cra,
  output logic [W-1:0] crb
);
  logic [W-1:0] cra_q, cra_d, crb_q, crb_d;
  ctrl_tgt_e    tgt_q, tgt_d;
  logic         ctrl_wr;

  always_comb begin
    ctrl_wr = wr_go & wr_sel;
    cra_d   = cra_q;
    crb_d   = crb_q;
    tgt_d   = tgt_q;
    if (ctrl_wr) begin
      if (tgt_q == TGT_B) begin
        crb_d = wr_dat;
        tgt_d = TGT_A;
      end else begin
        cra_d = wr_dat;
        tgt_d = wr_dat[CA_STEER] ? TGT_B : TGT_A;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cra_q <= '0;
      crb_q <= '0;
      tgt_q <= TGT_A;
    end else if (ctrl_wr) begin
      cra_q <= cra_d;
      crb_q <= crb_d;
      tgt_q <= tgt_d;
    end
  end

  assign cra = cra_q;
  assign crb = crb_q;

  p_steer_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && tgt_q == TGT_B) |=> (tgt_q == TGT_A) && $stable(cra_q));
  p_b_untouched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_q == TGT_A) |=> $stable(crb_q));
endmodule

// File: rtl/status_irq.sv
module status_irq
  import tone_host_pkg::*;
#(
  parameter int W = NIB
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_stb,
  input  logic         tx_stb,
  input  logic         tone_det,
  input  logic         ie,
  input  logic         burst_n,
  input  logic         rd_seen,
  input  logic         rd_sel,
  input  logic         rd_done,
  output logic [W-1:0] status,
  output logic         irq_n
);
  localparam int NF = ST_CLR_N;

  logic [NF-1:0] flag_q, flag_d, set_v, clr_v, snap_q, snap_d;
  logic          notone_q, notone_d;
  logic          burst_fin;

  always_comb begin
    burst_fin         = tx_stb & ~burst_n;
    set_v             = '0;
    set_v[ST_IRQ]     = ie & (rx_stb | burst_fin);
    set_v[ST_TXE]     = burst_fin;
    set_v[ST_RXF]     = rx_stb;
    clr_v             = (rd_done & rd_sel) ? snap_q : '0;
    if (rd_done)                snap_d = '0;
    else if (rd_seen && rd_sel) snap_d = snap_q | flag_q;
    else                        snap_d = snap_q;
    notone_d          = ~tone_det;
  end

  for (genvar i = 0; i < NF; i++) begin : g_flag
    assign flag_d[i] = set_v[i] | (flag_q[i] & ~clr_v[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= '0;
      snap_q   <= '0;
      notone_q <= 1'b1;
    end else begin
      flag_q   <= flag_d;
      snap_q   <= snap_d;
      notone_q <= notone_d;
    end
  end

  always_comb begin
    status            = '0;
    status[NF-1:0]    = flag_q;
    status[ST_NOTONE] = notone_q;
  end

  assign irq_n = ~(flag_q[ST_IRQ] & ie);

  p_rxf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb |=> status[ST_RXF]);
  p_rxf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && rd_sel && snap_q[ST_RXF] && !rx_stb) |=> !status[ST_RXF]);
  p_notone_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tone_det) |=> !status[ST_NOTONE]);
  p_irq_needs_ie_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> ie);
  p_no_irq_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie && !flag_q[ST_IRQ]) |=> !status[ST_IRQ]);
endmodule

// File: rtl/tone_host_regs.sv
module tone_host_regs
  import tone_host_pkg::*;
#(
  parameter int W = NIB
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic         reg_sel,
  inout  wire  [W-1:0] data,
  input  logic         rx_stb,
  input  logic [W-1:0] rx_code,
  input  logic         tx_stb,
  input  logic         tone_det,
  output logic [W-1:0] tx_data,
  output logic         tx_load,
  output logic [W-1:0] ctrl_a,
  output logic [W-1:0] ctrl_b,
  output logic         irq_n
);
  logic [1:0]   rst_sync_q;
  logic         rst_n_i;
  logic         wr_go, wr_sel, rd_seen, rd_sel, rd_done;
  logic [W-1:0] wr_dat, status, rdr_q, rdr_d, tdr_q, tdr_d;
  logic         tdr_wr, load_q;
  logic         bus_oe;
  logic [W-1:0] bus_val;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  host_strobe_sampler #(.W(W)) u_sampler (
    .clk(clk), .rst_n(rst_n_i), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .sel(reg_sel), .din(data), .wr_go(wr_go), .wr_sel(wr_sel),
    .wr_dat(wr_dat), .rd_seen(rd_seen), .rd_sel(rd_sel), .rd_done(rd_done)
  );

  ctrl_bank #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_i), .wr_go(wr_go), .wr_sel(wr_sel),
    .wr_dat(wr_dat), .cra(ctrl_a), .crb(ctrl_b)
  );

  status_irq #(.W(W)) u_status (
    .clk(clk), .rst_n(rst_n_i), .rx_stb(rx_stb), .tx_stb(tx_stb),
    .tone_det(tone_det), .ie(ctrl_a[CA_IE]), .burst_n(ctrl_b[CB_BURST_N]),
    .rd_seen(rd_seen), .rd_sel(rd_sel), .rd_done(rd_done),
    .status(status), .irq_n(irq_n)
  );

  // data registers
  always_comb begin
    tdr_wr = wr_go & ~wr_sel;
    tdr_d  = tdr_wr ? wr_dat : tdr_q;
    rdr_d  = rx_stb ? rx_code : rdr_q;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      tdr_q  <= '0;
      rdr_q  <= '0;
      load_q <= 1'b0;
    end else begin
      tdr_q  <= tdr_d;
      rdr_q  <= rdr_d;
      load_q <= tdr_wr;
    end
  end

  assign tx_data = tdr_q;
  assign tx_load = load_q;

  // read path
  always_comb begin
    bus_oe  = ~cs_n & ~rd_n;
    bus_val = reg_sel ? status : rdr_q;
  end
  assign data = bus_oe ? bus_val : {W{1'bz}};

  p_tdr_load_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    tdr_wr |=> (tx_data == $past(wr_dat)) && tx_load);
  p_rdr_latch_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    rx_stb |=> rdr_q == $past(rx_code));
  p_tdr_hold_r13: assert property (@(posedge clk) disable iff (!rst_n_i)
    !tdr_wr |=> $stable(tx_data) && !tx_load);
endmodule

// File: tb/tone_host_regs_tb.sv
module tone_host_regs_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, reg_sel = 1'b0;
  logic       rx_stb = 1'b0, tx_stb = 1'b0, tone_det = 1'b0;
  logic [3:0] rx_code = '0;
  logic [3:0] drv = '0;
  logic       drv_en = 1'b0;
  wire  [3:0] bus;
  logic [3:0] tx_data, ctrl_a, ctrl_b;
  logic       tx_load, irq_n;
  int         n_run = 0, n_fail = 0, load_cnt = 0;
  bit         done = 1'b0;

  assign bus = drv_en ? drv : 4'bzzzz;

  always #(CLK_PERIOD/2) clk = ~clk;

  tone_host_regs dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .reg_sel(reg_sel), .data(bus), .rx_stb(rx_stb), .rx_code(rx_code),
    .tx_stb(tx_stb), .tone_det(tone_det), .tx_data(tx_data),
    .tx_load(tx_load), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .irq_n(irq_n)
  );

  always @(negedge clk) if (tx_load) load_cnt++;

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic sel, input logic [3:0] val);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; reg_sel = sel; drv = val; drv_en = 1'b1;
    repeat (2) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1; drv_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_read(input logic sel, output logic [3:0] val, input bit stb_on_clear = 1'b0,
                          input logic [3:0] code = 4'h0);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; reg_sel = sel;
    #1 val = bus;
    @(negedge clk);
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    if (stb_on_clear) begin rx_stb = 1'b1; rx_code = code; end
    @(negedge clk);
    rx_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_rx(input logic [3:0] code);
    @(negedge clk); rx_stb = 1'b1; rx_code = code;
    @(negedge clk); rx_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_tx();
    @(negedge clk); tx_stb = 1'b1;
    @(negedge clk); tx_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [3:0] v;
    chk("R1 tx_data", tx_data, 4'h0);
    chk("R1 ctrl_a", ctrl_a, 4'h0);
    chk("R1 ctrl_b", ctrl_b, 4'h0);
    chk("R1 irq_n", {3'b0, irq_n}, 4'h1);
    chk("R1 no tx_load", load_cnt[3:0], 4'h0);
    bus_read(1'b1, v);
    chk("R1/R6 status after reset", v, 4'b1000);
  endtask

  task automatic t_tx_write();
    bus_write(1'b0, 4'hA);
    chk("R2 tx_data", tx_data, 4'hA);
    chk("R2 tx_load once", load_cnt[3:0], 4'h1);
    // R13: strobe with chip select high
    @(negedge clk); wr_n = 1'b0; reg_sel = 1'b0; drv = 4'h5; drv_en = 1'b1;
    repeat (3) @(negedge clk); wr_n = 1'b1; drv_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R13 tx_data unchanged", tx_data, 4'hA);
    chk("R13 no extra tx_load", load_cnt[3:0], 4'h1);
  endtask

  task automatic t_rx_path();
    logic [3:0] v;
    pulse_rx(4'h6);
    bus_read(1'b0, v);
    chk("R3 rx digit", v, 4'h6);
    bus_read(1'b1, v);
    chk("R7/R6 rx full shown", v, 4'b1100);
    bus_read(1'b1, v);
    chk("R8 rx full cleared", v, 4'b1000);
    bus_read(1'b0, v);
    chk("R3 digit kept after status read", v, 4'h6);
  endtask

  task automatic t_bus_hiz();
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; reg_sel = 1'b0; drv = 4'b0101; drv_en = 1'b1;
    #1 chk("R4 cs_n high", bus, 4'b0101);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b1; drv = 4'b1010;
    #1 chk("R4 rd_n high", bus, 4'b1010);
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b1; drv_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_indirect();
    bus_write(1'b1, 4'b1001);
    chk("R5 ctrl_a first", ctrl_a, 4'b1001);
    bus_write(1'b1, 4'b0110);
    chk("R5 ctrl_b steered", ctrl_b, 4'b0110);
    chk("R5 ctrl_a kept", ctrl_a, 4'b1001);
    bus_write(1'b1, 4'b0001);
    chk("R5 back to ctrl_a", ctrl_a, 4'b0001);
    chk("R5 ctrl_b kept", ctrl_b, 4'b0110);
  endtask

  task automatic t_burst();
    logic [3:0] v;
    pulse_tx();
    bus_read(1'b1, v);
    chk("R7 tx empty in burst", v, 4'b1010);
    bus_read(1'b1, v);
    chk("R8 tx empty cleared", v, 4'b1000);
    bus_write(1'b1, 4'b1000);
    bus_write(1'b1, 4'b0001);
    chk("R5 ctrl_b burst off", ctrl_b, 4'b0001);
    pulse_tx();
    bus_read(1'b1, v);
    chk("R7 tx strobe ignored outside burst", v, 4'b1000);
  endtask

  task automatic t_irq();
    logic [3:0] v;
    bus_write(1'b1, 4'b0000);
    pulse_rx(4'h2);
    chk("R11 irq_n high when disabled", {3'b0, irq_n}, 4'h1);
    bus_read(1'b1, v);
    chk("R11 no irq flag when disabled", v, 4'b1100);
    bus_write(1'b1, 4'b0100);
    pulse_rx(4'h3);
    chk("R10 irq_n low", {3'b0, irq_n}, 4'h0);
    bus_read(1'b1, v);
    chk("R10 irq flag shown", v, 4'b1101);
    chk("R12 irq_n released", {3'b0, irq_n}, 4'h1);
    bus_read(1'b1, v);
    chk("R8 all cleared", v, 4'b1000);
    pulse_rx(4'h4);
    chk("R10 irq_n low again", {3'b0, irq_n}, 4'h0);
    bus_write(1'b1, 4'b0000);
    chk("R11 masked at once", {3'b0, irq_n}, 4'h1);
    bus_read(1'b1, v);
    chk("R11 flag kept while masked", v, 4'b1101);
  endtask

  task automatic t_tone();
    logic [3:0] v;
    @(negedge clk); tone_det = 1'b1;
    repeat (2) @(negedge clk);
    bus_read(1'b1, v);
    chk("R9 tone present", v, 4'b0000);
    @(negedge clk); tone_det = 1'b0;
    repeat (2) @(negedge clk);
    bus_read(1'b1, v);
    chk("R9 tone absent, not cleared by read", v, 4'b1000);
    bus_read(1'b1, v);
    chk("R9 still set after read", v, 4'b1000);
  endtask

  task automatic t_survive();
    logic [3:0] v;
    pulse_rx(4'h9);
    bus_read(1'b1, v, 1'b1, 4'h3);
    chk("R8 first read", v, 4'b1100);
    bus_read(1'b1, v);
    chk("R8 late flag survives", v, 4'b1100);
    bus_read(1'b0, v);
    chk("R3 late digit", v, 4'h3);
    bus_read(1'b1, v);
    chk("R8 then cleared", v, 4'b1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_tx_write();
    t_rx_path();
    t_bus_hiz();
    t_indirect();
    t_burst();
    t_irq();
    t_tone();
    t_survive();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule